// File: doc/BRIEF.md
# NAND Page Read Phase Sequencer

This block produces the timed control strobes for one charge-integration read of a NAND string page. A read is started by a one-cycle request. The block then walks through five timed phases in a fixed order:

1. The sense latches are forced to their reset state.
2. The bitlines are precharged through the clamp held at its first level.
3. Precharge and clamp are both released so that bitline and sense node float while the cell current integrates.
4. The clamp control is switched to its second, lower level.
5. The latch strobe fires.

Each phase length is given in clock cycles on a set of duration inputs. These are sampled when the read starts. A field of zero selects a built-in default; at the 100 MHz design clock the precharge default is 4 µs and the evaluation default is 8 µs.

A per-bitline "sense node still high" input stands in for the analog sense node. During the strobe, a bitline whose sense node is still high flips its latch, and that bit reads 0 (programmed cell). Any other bitline keeps the reset state and reads 1 (erased cell). One cycle after the last strobe cycle the page data is presented together with a one-cycle completion pulse. Throughout the read, the addressed wordline of the string is driven at the select level and every other wordline at the pass level.

Top module: `nand_read_seq`

## Requirements
- R1: The cycle after an accepted start, `latch_set_o` rises and stays high for exactly the reset-phase duration, with every other strobe low.
- R2: Directly after the reset phase, `pre_en_o` and `clamp_v1_o` are both high for exactly the precharge duration.
- R3: Directly after precharge, `latch_set_o`, `pre_en_o`, `clamp_v1_o`, `clamp_v2_o` and `strobe_o` are all low for exactly the evaluation duration while `busy_o` stays high.
- R4: After evaluation, `clamp_v2_o` is high for the clamp-switch duration plus the strobe duration. `strobe_o` rises only once that clamp-switch duration has elapsed and then stays high for the strobe duration. `clamp_v1_o` and `clamp_v2_o` are never high together.
- R5: Bit i of the page reads 0 if `sense_hi_i[i]` was high in at least one strobe cycle and 1 otherwise. The value of `sense_hi_i` outside strobe cycles has no effect.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last strobe cycle. `data_o` takes the new page value in that cycle and holds its value at all other times.
- R7: While `busy_o` is high, `wl_sel_o` is one-hot at the wordline index sampled at start, and `wl_pass_o` is its bitwise complement. While idle, both are all zero.
- R8: A duration field of zero selects its default: 2 cycles (reset), 400 (precharge), 800 (evaluation), 2 (clamp switch), 1 (strobe).
- R9: Durations and wordline index are sampled only when a start is accepted from idle. A start or a change to those inputs during a read has no effect, and after completion the block stays idle until the next start.
- R10: An asynchronous reset immediately returns the block to idle: all strobes, `done_o`, `busy_o` and the wordline outputs go low, and `data_o` goes to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read request, accepted only when idle |
| wl_idx_i | input | WL_W | Index of the wordline to read within the string |
| rst_cyc_i | input | CNT_W | Latch-reset phase length in cycles, 0 selects default |
| pre_cyc_i | input | CNT_W | Precharge phase length in cycles, 0 selects default |
| eval_cyc_i | input | CNT_W | Evaluation phase length in cycles, 0 selects default |
| clamp_cyc_i | input | CNT_W | Clamp-switch settle length in cycles, 0 selects default |
| strb_cyc_i | input | CNT_W | Strobe length in cycles, 0 selects default |
| sense_hi_i | input | NUM_BL | Per-bitline sense node still high |
| latch_set_o | output | 1 | Force sense latches to reset state |
| pre_en_o | output | 1 | Bitline precharge device enable |
| clamp_v1_o | output | 1 | Clamp gate at first (precharge) level |
| clamp_v2_o | output | 1 | Clamp gate at second (lower) level |
| wl_sel_o | output | NUM_WL | Per wordline: drive select level |
| wl_pass_o | output | NUM_WL | Per wordline: drive pass level |
| strobe_o | output | 1 | Latch strobe |
| data_o | output | NUM_BL | Page data of the last completed read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Read in progress |

## Verification
Reads are run with short distinct durations in each phase, with all-minimum durations and with all-zero fields. Comparing each strobe's cycle-by-cycle window against its expected slot separates an off-by-one in one phase from a wrong phase order, and shows whether a default is substituted. Sense patterns mix alternating, all-high and all-low bitlines. A pattern may be presented in only one late strobe cycle while noise is driven outside the strobe, which tells a sticky strobe-gated capture apart from one that samples at the wrong moment or listens outside the strobe. A mid-read start with altered inputs, and an asynchronous reset during precharge, show whether state sampled at start is protected and whether reset clears everything.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_RST   = 3'd1,
      PH_PRE   = 3'd2,
      PH_EVAL  = 3'd3,
      PH_CLAMP = 3'd4,
      PH_STRB  = 3'd5,
      PH_DONE  = 3'd6
   } nrd_phase_e;

   localparam int NRD_SLOTS = 5;

   // Duration slot used by a timed phase.
   function automatic logic [2:0] timed_slot(nrd_phase_e p);
      case (p)
         PH_RST:   return 3'd0;
         PH_PRE:   return 3'd1;
         PH_EVAL:  return 3'd2;
         PH_CLAMP: return 3'd3;
         PH_STRB:  return 3'd4;
         default:  return 3'd0;
      endcase
   endfunction

   function automatic logic is_timed(nrd_phase_e p);
      return (p == PH_RST) || (p == PH_PRE) || (p == PH_EVAL) ||
             (p == PH_CLAMP) || (p == PH_STRB);
   endfunction

   function automatic nrd_phase_e next_phase(nrd_phase_e p);
      case (p)
         PH_RST:   return PH_PRE;
         PH_PRE:   return PH_EVAL;
         PH_EVAL:  return PH_CLAMP;
         PH_CLAMP: return PH_STRB;
         PH_STRB:  return PH_DONE;
         default:  return PH_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/nrd_dur_latch.sv
module nrd_dur_latch #(
   parameter int CNT_W     = 12,
   parameter int DEF_RST   = 2,
   parameter int DEF_PRE   = 400,
   parameter int DEF_EVAL  = 800,
   parameter int DEF_CLAMP = 2,
   parameter int DEF_STRB  = 1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   load_i,
   input  logic [nrd_pkg::NRD_SLOTS-1:0][CNT_W-1:0] raw_i,
   output logic [nrd_pkg::NRD_SLOTS-1:0][CNT_W-1:0] dur_o
);
   localparam int NS = nrd_pkg::NRD_SLOTS;
   localparam int DEFS [NS] = '{DEF_RST, DEF_PRE, DEF_EVAL, DEF_CLAMP, DEF_STRB};

   for (genvar s = 0; s < NS; s++) begin : g_slot
      if (DEFS[s] < 1 || DEFS[s] >= (2 ** CNT_W)) begin : g_bad_def
         $error("nrd_dur_latch: default of slot %0d does not fit CNT_W", s);
      end

      localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEFS[s]);
      logic [CNT_W-1:0] dur_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dur_q <= DEF_V;
         end else if (load_i) begin
            dur_q <= (raw_i[s] == '0) ? DEF_V : raw_i[s];
         end
      end

      assign dur_o[s] = dur_q;
   end

endmodule

// File: rtl/nrd_phase_ctrl.sv
module nrd_phase_ctrl #(
   parameter int CNT_W = 12
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     start_i,
   input  logic [nrd_pkg::NRD_SLOTS-1:0][CNT_W-1:0] dur_i,
   output nrd_pkg::nrd_phase_e                      phase_o,
   output logic                                     accept_o,
   output logic                                     last_o
);
   import nrd_pkg::*;

   nrd_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             term;

   always_comb begin
      limit    = dur_i[timed_slot(phase_q)] - CNT_W'(1);
      term     = is_timed(phase_q) && (cnt_q == limit);
      accept_o = start_i && (phase_q == PH_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               cnt_q <= '0;
               if (accept_o) phase_q <= PH_RST;
            end
            PH_DONE: begin
               cnt_q   <= '0;
               phase_q <= PH_IDLE;
            end
            default: begin
               if (term) begin
                  phase_q <= next_phase(phase_q);
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign phase_o = phase_q;
   assign last_o  = term;

endmodule

// File: rtl/nrd_latch_bank.sv
module nrd_latch_bank #(
   parameter int NUM_BL = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              strobe_i,
   input  logic              commit_i,
   input  logic [NUM_BL-1:0] sense_i,
   output logic [NUM_BL-1:0] data_o
);
   for (genvar b = 0; b < NUM_BL; b++) begin : g_bl
      logic flip_q;
      logic data_q;
      logic hit;

      assign hit = strobe_i && sense_i[b];

      // Sticky sense latch: cleared in the reset phase, flipped by any strobe hit.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flip_q <= 1'b0;
         end else if (clear_i) begin
            flip_q <= 1'b0;
         end else if (hit) begin
            flip_q <= 1'b1;
         end
      end

      // Output register: a flipped latch reads 0, an untouched latch reads 1.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= 1'b1;
         end else if (commit_i) begin
            data_q <= !(flip_q || hit);
         end
      end

      assign data_o[b] = data_q;
   end

endmodule

// File: rtl/nrd_wl_drive.sv
module nrd_wl_drive #(
   parameter int NUM_WL = 32,
   localparam int WL_W  = $clog2(NUM_WL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WL_W-1:0]   idx_i,
   input  logic              active_i,
   output logic [NUM_WL-1:0] sel_o,
   output logic [NUM_WL-1:0] pass_o
);
   logic [WL_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (load_i) begin
         idx_q <= idx_i;
      end
   end

   for (genvar w = 0; w < NUM_WL; w++) begin : g_wl
      localparam logic [WL_W-1:0] MY_IDX = WL_W'(w);
      assign sel_o[w]  = active_i && (idx_q == MY_IDX);
      assign pass_o[w] = active_i && (idx_q != MY_IDX);
   end

endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq #(
   parameter int NUM_BL        = 8,
   parameter int NUM_WL        = 32,
   parameter int CNT_W         = 12,
   parameter int DEF_RST_CYC   = 2,
   parameter int DEF_PRE_CYC   = 400,
   parameter int DEF_EVAL_CYC  = 800,
   parameter int DEF_CLAMP_CYC = 2,
   parameter int DEF_STRB_CYC  = 1,
   localparam int WL_W         = $clog2(NUM_WL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WL_W-1:0]   wl_idx_i,
   input  logic [CNT_W-1:0]  rst_cyc_i,
   input  logic [CNT_W-1:0]  pre_cyc_i,
   input  logic [CNT_W-1:0]  eval_cyc_i,
   input  logic [CNT_W-1:0]  clamp_cyc_i,
   input  logic [CNT_W-1:0]  strb_cyc_i,
   input  logic [NUM_BL-1:0] sense_hi_i,
   output logic              latch_set_o,
   output logic              pre_en_o,
   output logic              clamp_v1_o,
   output logic              clamp_v2_o,
   output logic [NUM_WL-1:0] wl_sel_o,
   output logic [NUM_WL-1:0] wl_pass_o,
   output logic              strobe_o,
   output logic [NUM_BL-1:0] data_o,
   output logic              done_o,
   output logic              busy_o
);
   import nrd_pkg::*;

   if (NUM_BL < 1) begin : g_bad_bl
      $error("nand_read_seq: NUM_BL must be at least 1");
   end
   if (NUM_WL < 2 || NUM_WL != (2 ** WL_W)) begin : g_bad_wl
      $error("nand_read_seq: NUM_WL must be a power of two of at least 2");
   end
   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
      $error("nand_read_seq: CNT_W out of range");
   end

   logic [NRD_SLOTS-1:0][CNT_W-1:0] raw_dur;
   logic [NRD_SLOTS-1:0][CNT_W-1:0] dur;
   nrd_phase_e                      phase;
   logic                            accept;
   logic                            last;

   assign raw_dur = {strb_cyc_i, clamp_cyc_i, eval_cyc_i, pre_cyc_i, rst_cyc_i};

   nrd_dur_latch #(
      .CNT_W     (CNT_W),
      .DEF_RST   (DEF_RST_CYC),
      .DEF_PRE   (DEF_PRE_CYC),
      .DEF_EVAL  (DEF_EVAL_CYC),
      .DEF_CLAMP (DEF_CLAMP_CYC),
      .DEF_STRB  (DEF_STRB_CYC)
   ) dur_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .raw_i  (raw_dur),
      .dur_o  (dur)
   );

   nrd_phase_ctrl #(.CNT_W(CNT_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .dur_i    (dur),
      .phase_o  (phase),
      .accept_o (accept),
      .last_o   (last)
   );

   always_comb begin
      latch_set_o = (phase == PH_RST);
      pre_en_o    = (phase == PH_PRE);
      clamp_v1_o  = (phase == PH_PRE);
      clamp_v2_o  = (phase == PH_CLAMP) || (phase == PH_STRB);
      strobe_o    = (phase == PH_STRB);
      done_o      = (phase == PH_DONE);
      busy_o      = (phase != PH_IDLE);
   end

   nrd_latch_bank #(.NUM_BL(NUM_BL)) latch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (latch_set_o),
      .strobe_i (strobe_o),
      .commit_i (strobe_o && last),
      .sense_i  (sense_hi_i),
      .data_o   (data_o)
   );

   nrd_wl_drive #(.NUM_WL(NUM_WL)) wl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .idx_i    (wl_idx_i),
      .active_i (busy_o),
      .sel_o    (wl_sel_o),
      .pass_o   (wl_pass_o)
   );

endmodule

// File: rtl/nand_read_seq_chk.sv
module nand_read_seq_chk #(
   parameter int NUM_BL = 8,
   parameter int NUM_WL = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              latch_set_o,
   input logic              pre_en_o,
   input logic              clamp_v1_o,
   input logic              clamp_v2_o,
   input logic [NUM_WL-1:0] wl_sel_o,
   input logic [NUM_WL-1:0] wl_pass_o,
   input logic              strobe_o,
   input logic [NUM_BL-1:0] data_o,
   input logic              done_o,
   input logic              busy_o
);
   assert_rst_before_pre_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pre_en_o) |-> $past(latch_set_o));

   assert_pre_with_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pre_en_o |-> (clamp_v1_o && !latch_set_o));

   assert_float_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pre_en_o) |-> (!clamp_v1_o && !clamp_v2_o && !strobe_o && busy_o));

   assert_strobe_on_low_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> clamp_v2_o);

   assert_switch_before_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_o) |-> $past(clamp_v2_o));

   assert_clamp_levels_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(clamp_v1_o && clamp_v2_o));

   assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_o) |-> done_o);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(data_o));

   assert_wl_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> ($onehot(wl_sel_o) && (wl_pass_o == ~wl_sel_o)));

   assert_wl_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> ((wl_sel_o == '0) && (wl_pass_o == '0)));

endmodule

bind nand_read_seq nand_read_seq_chk #(.NUM_BL(NUM_BL), .NUM_WL(NUM_WL)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .latch_set_o (latch_set_o),
   .pre_en_o    (pre_en_o),
   .clamp_v1_o  (clamp_v1_o),
   .clamp_v2_o  (clamp_v2_o),
   .wl_sel_o    (wl_sel_o),
   .wl_pass_o   (wl_pass_o),
   .strobe_o    (strobe_o),
   .data_o      (data_o),
   .done_o      (done_o),
   .busy_o      (busy_o)
);

// File: tb/nand_read_seq_tb_top.sv
`timescale 1ns/1ps
module nand_read_seq_tb_top;
   localparam int NBL   = 8;
   localparam int NWL   = 32;
   localparam int CW    = 12;
   localparam int WLW   = 5;
   localparam int D_RST = 2, D_PRE = 400, D_EVAL = 800, D_CLAMP = 2, D_STRB = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [WLW-1:0]  wl_idx = '0;
   logic [CW-1:0]   t_rst = '0, t_pre = '0, t_eval = '0, t_clamp = '0, t_strb = '0;
   logic [NBL-1:0]  sense = '0;
   logic            latch_set, pre_en, clamp_v1, clamp_v2, strobe, done, busy;
   logic [NWL-1:0]  wl_sel, wl_pass;
   logic [NBL-1:0]  data;

   int vectors = 0;
   int miscompares = 0;
   logic [NBL-1:0] prev_data = '1;

   always #5 clk = ~clk;

   nand_read_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .wl_idx_i(wl_idx),
      .rst_cyc_i(t_rst), .pre_cyc_i(t_pre), .eval_cyc_i(t_eval),
      .clamp_cyc_i(t_clamp), .strb_cyc_i(t_strb), .sense_hi_i(sense),
      .latch_set_o(latch_set), .pre_en_o(pre_en), .clamp_v1_o(clamp_v1),
      .clamp_v2_o(clamp_v2), .wl_sel_o(wl_sel), .wl_pass_o(wl_pass),
      .strobe_o(strobe), .data_o(data), .done_o(done), .busy_o(busy)
   );

   task automatic check(input logic ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int eff(input int v, input int d);
      return (v == 0) ? d : v;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // One read. pick: strobe cycle (0-based) in which the pattern is shown.
   // poke: issue a start with altered inputs in the middle of the read (R9).
   task automatic run_read(input int tr, input int tp, input int te, input int tc,
                           input int ts, input int wl, input logic [NBL-1:0] pat,
                           input logic [NBL-1:0] noise, input int pick, input bit poke,
                           input string tag);
      int r, p, e, c, s, a, dn;
      logic [6:0] bad_v [5];
      logic [6:0] bad_e [5];
      bit         bad [5];
      bit         wl_bad;
      logic [NWL-1:0] wl_exp;
      r = eff(tr, D_RST); p = eff(tp, D_PRE); e = eff(te, D_EVAL);
      c = eff(tc, D_CLAMP); s = eff(ts, D_STRB);
      a = r + p + e; dn = a + c + s + 1;
      wl_exp = NWL'(1) << wl;
      wl_bad = 1'b0;
      for (int k = 0; k < 5; k++) begin bad[k] = 1'b0; bad_v[k] = '0; bad_e[k] = '0; end
      t_rst = CW'(tr); t_pre = CW'(tp); t_eval = CW'(te); t_clamp = CW'(tc); t_strb = CW'(ts);
      wl_idx = WLW'(wl);
      sense = noise;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 1; n <= dn + 1; n++) begin
         logic ls, pe, cl, st, dnx, by;
         logic [6:0] ev, av;
         int bk;
         ls = (n <= r);
         pe = (n > r) && (n <= r + p);
         cl = (n > a) && (n <= a + c + s);
         st = (n > a + c) && (n <= a + c + s);
         dnx = (n == dn);
         by = (n <= dn);
         ev = {ls, pe, pe, cl, st, dnx, by};
         av = {latch_set, pre_en, clamp_v1, clamp_v2, strobe, done, busy};
         bk = (n <= r) ? 0 : (n <= r + p) ? 1 : (n <= a) ? 2 : (n <= a + c + s) ? 3 : 4;
         if (av !== ev && !bad[bk]) begin bad[bk] = 1'b1; bad_v[bk] = av; bad_e[bk] = ev; end
         if (by && (wl_sel !== wl_exp || wl_pass !== ~wl_exp)) wl_bad = 1'b1;
         if (n == dn - 1)
            check(data === prev_data, {"R6 data held before done ", tag}, 64'(data), 64'(prev_data));
         if (n == dn)
            check(data === ~pat, {"R5 page data ", tag}, 64'(data), 64'(~pat));
         if (st) sense = ((n - (a + c) - 1) == pick) ? pat : '0;
         else    sense = noise;
         if (poke && n == r + 2) begin
            start = 1'b1; t_rst = 3; t_pre = 7; t_eval = 9; t_clamp = 5; t_strb = 4;
            wl_idx = WLW'(wl + 1);
         end
         if (poke && n == r + 3) start = 1'b0;
         @(negedge clk);
      end
      check(!bad[0], {"R1 latch reset phase ", tag}, 64'(bad_v[0]), 64'(bad_e[0]));
      check(!bad[1], {"R2 precharge phase ", tag}, 64'(bad_v[1]), 64'(bad_e[1]));
      check(!bad[2], {"R3 evaluation phase ", tag}, 64'(bad_v[2]), 64'(bad_e[2]));
      check(!bad[3], {"R4 clamp switch and strobe ", tag}, 64'(bad_v[3]), 64'(bad_e[3]));
      check(!bad[4], {"R6 done pulse and return ", tag}, 64'(bad_v[4]), 64'(bad_e[4]));
      check(!wl_bad, {"R7 wordline levels ", tag}, 64'(wl_sel), 64'(wl_exp));
      for (int k = 0; k < 3; k++) begin
         check(!busy && wl_sel == '0 && wl_pass == '0, {"R9 stays idle ", tag},
               64'(busy), 64'd0);
         @(negedge clk);
      end
      prev_data = ~pat;
      sense = '0;
   endtask

   task automatic t_reset_state();
      check(!latch_set && !pre_en && !clamp_v1 && !clamp_v2 && !strobe && !done && !busy,
            "R10 strobes low after reset", 64'({latch_set, pre_en, clamp_v1, clamp_v2, strobe, done, busy}), 64'd0);
      check(data === '1, "R10 data all ones after reset", 64'(data), 64'hff);
      check(wl_sel == '0 && wl_pass == '0, "R7 wordlines idle after reset", 64'(wl_pass), 64'd0);
   endtask

   task automatic t_reset_mid_read();
      t_rst = 1; t_pre = 30; t_eval = 30; t_clamp = 1; t_strb = 1; wl_idx = 4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      check(!pre_en && !clamp_v1 && !busy && !done && !strobe && !latch_set,
            "R10 async reset clears strobes", 64'({pre_en, clamp_v1, busy}), 64'd0);
      check(wl_sel == '0 && data === '1, "R10 async reset clears wordlines and data",
            64'(wl_sel), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      prev_data = '1;
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      do_reset();
      t_reset_state();
      run_read(2, 5, 7, 3, 2, 3, 8'hA5, 8'h00, 0, 1'b0, "basic");
      run_read(1, 1, 1, 1, 1, 0, 8'hFF, 8'h00, 0, 1'b0, "minimum");
      run_read(3, 4, 6, 2, 4, 31, 8'h3C, 8'hFF, 3, 1'b0, "late strobe with noise");
      run_read(2, 3, 9, 1, 3, 17, 8'h00, 8'hFF, 0, 1'b0, "noise only outside strobe");
      run_read(0, 0, 0, 0, 0, 9, 8'h5A, 8'h81, 0, 1'b0, "R8 defaults");
      run_read(2, 6, 8, 2, 2, 12, 8'hC3, 8'h00, 1, 1'b1, "R9 busy start ignored");
      t_reset_mid_read();
      run_read(1, 2, 3, 1, 1, 5, 8'h0F, 8'h00, 0, 1'b0, "after async reset");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule